// File: doc/BRIEF.md
# Daisy-Chainable SPI Command Receiver

This block is the serial front end of a small configurable peripheral. A host shifts 16-bit command words into it over an SPI link. Each word is an instruction byte followed by a data byte, both sent most significant bit first. The instruction picks an operation and a target register. The decoded command takes effect only at the moment chip select is released. If the transaction carried a number of serial clocks that is not a whole multiple of sixteen, the command is thrown away.

The serial output lets several such receivers share one chain. During a transaction it first sends sixteen zeros. After that it repeats whatever arrived on the serial input, sixteen clocks later. While chip select is high the output is actively driven low.

All three serial inputs are sampled by a faster system clock through two-flop synchronizers with edge detection, so the serial clock must run below a quarter of the system clock rate. Both clock polarities are accepted: idle low and idle high. In both, data is taken on rising edges of the serial clock and the output moves on falling edges.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset, `gain_q`, `chan_q`, `shdn_q`, `upd_stb` and `so` are all 0.
- R2: A frame is 16 bits, MSB first: instruction byte, then data byte. The opcode is instruction bits [7:5]. Opcode 3'b010 writes the data byte to `gain_q` when instruction bit [0] is 0 and to `chan_q` when it is 1. Instruction bits [4:1] are ignored. The write becomes visible only after `cs_n` rises.
- R3: Opcode 3'b001 sets `shdn_q`, and any write (opcode 3'b010) clears it. Opcode 3'b000 and every other opcode leave all outputs unchanged.
- R4: If the number of `sck` rising edges while `cs_n` is low is not a nonzero multiple of 16 (this includes zero), no output register changes and no strobe is issued.
- R5: If a frame has a valid count greater than 16, only the last 16 bits received are decoded.
- R6: Frames behave the same whether `sck` idles low or idles high.
- R7: Within a transaction, `so` carries 0 for the first 16 bit periods. It then carries the bits received on `si` delayed by 16 clocks, and it changes after falling `sck` edges.
- R8: While `cs_n` is high, `so` is driven 0.
- R9: `upd_stb` is high for exactly one cycle per applied write and stays low for any other command or an aborted frame.
- R10: `gain_q`, `chan_q` and `shdn_q` change only in cycles where a valid command is applied. `gain_q` and `chan_q` change only together with `upd_stb`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, push-pull |
| gain_q | output | 8 | Gain register |
| chan_q | output | 8 | Channel register |
| shdn_q | output | 1 | Shutdown flag |
| upd_stb | output | 1 | One-cycle pulse on a register write |

## Verification
A table of single-word frames alternates the two clock polarities. It covers writes to each register, a write whose unused instruction bits are set, a no-op, a shutdown and an unrecognised opcode. This separates correct opcode and address decoding from decoding that looks at the wrong bits. Frames of 17 clocks and of zero clocks must be rejected, which shows that the count rule is checked at chip-select release. Frames of 32 and 48 clocks show that only the final word is applied and that the serial output replays the earlier words after the sixteen-zero prefix.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_NOP   = 3'b000,
    OP_SHDN  = 3'b001,
    OP_WRITE = 3'b010
  } opcode_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int            N       = 3,
  parameter int            STAGES  = 2,
  parameter logic [N-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {(STAGES+1){RST_VAL[g]}};
      else        pipe <= {pipe[STAGES-1:0], din[g]};
    end
    assign lvl[g]  = pipe[STAGES-1];
    assign rise[g] = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall[g] = ~pipe[STAGES-1] & pipe[STAGES];
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int WORD_W = spi_cmd_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              si_lvl,
  output logic              so,
  output logic              cmd_valid,
  output logic [WORD_W-1:0] cmd_word
);
  localparam int               CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg_q, shreg_d, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              seen_q, seen_d, so_d, vld_d;

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    seen_d  = seen_q;
    so_d    = so;
    vld_d   = 1'b0;
    word_d  = cmd_word;
    if (cs_lvl) so_d = 1'b0;
    if (cs_fall) begin
      shreg_d = '0;
      cnt_d   = '0;
      seen_d  = 1'b0;
      so_d    = 1'b0;
    end else if (!cs_lvl) begin
      if (sck_rise) begin
        shreg_d = {shreg_q[WORD_W-2:0], si_lvl};
        cnt_d   = cnt_q + 1'b1;
        if (cnt_q == LAST) seen_d = 1'b1;
      end
      if (sck_fall) so_d = shreg_q[WORD_W-1];
    end
    if (cs_rise) begin
      vld_d  = seen_q && (cnt_q == '0);
      word_d = shreg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q   <= '0;
      cnt_q     <= '0;
      seen_q    <= 1'b0;
      so        <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
    end else begin
      shreg_q   <= shreg_d;
      cnt_q     <= cnt_d;
      seen_q    <= seen_d;
      so        <= so_d;
      cmd_valid <= vld_d;
      cmd_word  <= word_d;
    end
  end
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_cmd_pkg::*;
#(
  parameter int WORD_W = spi_cmd_pkg::WORD_W,
  parameter int DATA_W = spi_cmd_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  output logic [DATA_W-1:0] gain_q,
  output logic [DATA_W-1:0] chan_q,
  output logic              shdn_q,
  output logic              upd_stb
);
  localparam int INSTR_W = WORD_W - DATA_W;

  logic [INSTR_W-1:0] instr;
  logic [DATA_W-1:0]  data, gain_d, chan_d;
  logic               shdn_d, stb_d, unused_instr;
  opcode_e            op;

  assign instr        = cmd_word[WORD_W-1 -: INSTR_W];
  assign data         = cmd_word[DATA_W-1:0];
  assign op           = opcode_e'(instr[INSTR_W-1 -: 3]);
  assign unused_instr = ^instr[INSTR_W-4:1];

  always_comb begin
    gain_d = gain_q;
    chan_d = chan_q;
    shdn_d = shdn_q;
    stb_d  = 1'b0;
    if (cmd_valid) begin
      case (op)
        OP_WRITE: begin
          stb_d  = 1'b1;
          shdn_d = 1'b0;
          if (instr[0]) chan_d = data;
          else          gain_d = data;
        end
        OP_SHDN: shdn_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q  <= '0;
      chan_q  <= '0;
      shdn_q  <= 1'b0;
      upd_stb <= 1'b0;
    end else begin
      gain_q  <= gain_d;
      chan_q  <= chan_d;
      shdn_q  <= shdn_d;
      upd_stb <= stb_d;
    end
  end
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx #(
  parameter int WORD_W = spi_cmd_pkg::WORD_W,
  parameter int DATA_W = spi_cmd_pkg::BYTE_W,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic [DATA_W-1:0] gain_q,
  output logic [DATA_W-1:0] chan_q,
  output logic              shdn_q,
  output logic              upd_stb
);
  logic              rst_meta, rst_n_i;
  logic [2:0]        in_lvl, in_rise, in_fall;
  logic              cs_lvl, cs_rise, cs_fall, cmd_valid, unused_edges;
  logic [WORD_W-1:0] cmd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  spi_in_sync #(.N(3), .STAGES(SYNC_N), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .din({si, sck, cs_n}),
    .lvl(in_lvl), .rise(in_rise), .fall(in_fall)
  );

  assign cs_lvl       = in_lvl[0];
  assign cs_rise      = in_rise[0];
  assign cs_fall      = in_fall[0];
  assign unused_edges = ^{in_rise[2], in_fall[2], in_lvl[1]};

  spi_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n_i), .cs_lvl(cs_lvl), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sck_rise(in_rise[1]), .sck_fall(in_fall[1]),
    .si_lvl(in_lvl[2]), .so(so), .cmd_valid(cmd_valid), .cmd_word(cmd_word)
  );

  spi_cmd_decode #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n_i), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .gain_q(gain_q), .chan_q(chan_q), .shdn_q(shdn_q), .upd_stb(upd_stb)
  );
endmodule

// File: rtl/spi_cmd_rx_chk.sv
module spi_cmd_rx_chk #(
  parameter int DATA_W = spi_cmd_pkg::BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_lvl,
  input logic              cmd_valid,
  input logic              so,
  input logic [DATA_W-1:0] gain_q,
  input logic [DATA_W-1:0] chan_q,
  input logic              shdn_q,
  input logic              upd_stb
);
  assert_so_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |=> !so);

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);

  assert_gain_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> $stable(gain_q));

  assert_chan_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> $stable(chan_q));

  assert_shdn_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shdn_q) |-> $past(cmd_valid));

  assert_apply_on_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cs_lvl);
endmodule

bind spi_cmd_rx spi_cmd_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .cmd_valid(cmd_valid),
  .so(so), .gain_q(gain_q), .chan_q(chan_q), .shdn_q(shdn_q), .upd_stb(upd_stb)
);

// File: tb/spi_cmd_rx_test.sv
module spi_cmd_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       si = 1'b0;
  logic       so, shdn_q, upd_stb;
  logic [7:0] gain_q, chan_q;

  int n_cmp = 0;
  int n_bad = 0;
  int stb_total = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_cmd_rx uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so),
    .gain_q(gain_q), .chan_q(chan_q), .shdn_q(shdn_q), .upd_stb(upd_stb)
  );

  always @(posedge clk) if (upd_stb === 1'b1) stb_total++;

  // [33:18] word, [17:10] gain, [9:2] chan, [1] shutdown, [0] strobe expected
  localparam logic [33:0] VEC [8] = '{
    {16'h403C, 8'h3C, 8'h00, 1'b0, 1'b1},
    {16'h41A5, 8'h3C, 8'hA5, 1'b0, 1'b1},
    {16'h00FF, 8'h3C, 8'hA5, 1'b0, 1'b0},
    {16'h2000, 8'h3C, 8'hA5, 1'b1, 1'b0},
    {16'h4007, 8'h07, 8'hA5, 1'b0, 1'b1},
    {16'hE155, 8'h07, 8'hA5, 1'b0, 1'b0},
    {16'h4312, 8'h07, 8'h12, 1'b0, 1'b1},
    {16'h5E99, 8'h99, 8'h12, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Shift nbits (MSB first from bit nbits-1), checking SO before every rising edge (R7).
  task automatic xfer(input logic [63:0] bits, input int nbits, input bit idle_hi);
    sck = idle_hi;
    repeat (4) @(posedge clk);
    cs_n = 1'b0;
    repeat (8) @(posedge clk);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      si  = bits[nbits-1-i];
      repeat (8) @(posedge clk);
      @(negedge clk);
      chk("R7 so stream", {31'd0, so}, (i < 16) ? 32'd0 : {31'd0, bits[nbits-1-(i-16)]});
      sck = 1'b1;
      repeat (8) @(posedge clk);
    end
    if (!idle_hi) begin
      sck = 1'b0;
      repeat (8) @(posedge clk);
    end
    cs_n = 1'b1;
    si   = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R8 so idle low", {31'd0, so}, 32'd0);
  endtask

  task automatic expect_regs(input string req, input logic [7:0] g, input logic [7:0] c,
                             input logic s, input int stb_exp, input int stb_before);
    chk(req, {24'd0, gain_q}, {24'd0, g});
    chk(req, {24'd0, chan_q}, {24'd0, c});
    chk(req, {31'd0, shdn_q}, {31'd0, s});
    chk({req, " R9 strobes"}, stb_total - stb_before, stb_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    int snap;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    expect_regs("R1 reset", 8'h00, 8'h00, 1'b0, 0, 0);
    chk("R1 reset so", {31'd0, so}, 32'd0);
    chk("R1 reset strobe", {31'd0, upd_stb}, 32'd0);

    // R2 R3 R6 R9 table, alternating clock polarity
    for (int k = 0; k < 8; k++) begin
      snap = stb_total;
      xfer({48'd0, VEC[k][33:18]}, 16, k[0]);
      expect_regs($sformatf("R2/R3/R6 vec %0d", k), VEC[k][17:10], VEC[k][9:2],
                  VEC[k][1], int'(VEC[k][0]), snap);
    end

    // R4 17 clocks: last 16 bits would write gain 0x55, must be dropped
    snap = stb_total;
    xfer({47'd0, 17'h04055}, 17, 1'b0);
    expect_regs("R4 abort 17", 8'h99, 8'h12, 1'b0, 0, snap);

    // R4 zero clocks
    snap = stb_total;
    xfer(64'd0, 0, 1'b1);
    expect_regs("R4 abort 0", 8'h99, 8'h12, 1'b0, 0, snap);

    // R5 32 clocks, idle-high: only second word (chan 0x22) applies; SO replays first
    snap = stb_total;
    xfer({32'd0, 16'h4011, 16'h4122}, 32, 1'b1);
    expect_regs("R5 two words", 8'h99, 8'h22, 1'b0, 1, snap);

    // R5 48 clocks, idle-low
    snap = stb_total;
    xfer({16'd0, 16'h2000, 16'h4033, 16'h4166}, 48, 1'b0);
    expect_regs("R5 three words", 8'h99, 8'h66, 1'b0, 1, snap);

    // R3 shutdown then R1 reset mid-run
    snap = stb_total;
    xfer({48'd0, 16'h20AA}, 16, 1'b0);
    expect_regs("R3 shutdown", 8'h99, 8'h66, 1'b1, 0, snap);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_regs("R1 mid reset", 8'h00, 8'h00, 1'b0, 0, stb_total);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R3 write clears shutdown, R10 other register kept
    snap = stb_total;
    xfer({48'd0, 16'h2000}, 16, 1'b1);
    xfer({48'd0, 16'h4180}, 16, 1'b1);
    expect_regs("R3/R10 write clears shdn", 8'h00, 8'h80, 1'b0, 1, snap);

    done = 1'b1;
    report();
  end
endmodule